// File: doc/BRIEF.md
# Threshold-to-Raw Code Converter with Tolerance Margins

The block turns a threshold in millivolts into the 12-bit raw code that a window comparator on an ADC channel is programmed with. It gets the channel's calibration data (the millivolt-per-code gain scaled by 1000, the gain-error factor k scaled by 1000, a code offset scaled by 1000, and a flag that says whether the channel is calibrated), together with a direction: rising or falling. First the threshold is divided down to an ideal code. On a calibrated channel the calibration error is applied on top of that. After that, a worst-case margin for integral nonlinearity, gain error and offset error moves the code outward. Rising thresholds go up and falling thresholds go down, so a comparator trip is never missed because of converter tolerance.

One request is taken when `req_valid` is high and `busy` is low. Each conversion step uses one shared sequential signed divider that truncates toward zero. The result appears on `res_valid` as a one-cycle pulse. A request whose threshold is outside the 12-bit range gets a one-cycle `res_reject` pulse and produces no result. A request with a gain of zero returns code 0 at once, with `res_err` set.

Top module: `thresh_code_conv`

## Requirements
- R1: The ideal code is trunc(req_mv·1000 / cal_gain), rounded toward zero, with signed operands.
- R2: On a calibrated channel (cal_valid_ch=1) the ideal code c becomes trunc((c·cal_k + cal_offset)/1000) when req_rise=1 and trunc((c·cal_k − cal_offset)/1000) when req_rise=0. On an uncalibrated channel this step is skipped.
- R3: The code after R1/R2 becomes trunc(((c + INL)·(1000 + GE))/1000) + OE, and this value is clamped to 0…4095 on res_code.
- R4: On a calibrated channel the margins are INL=+2, GE=+2, OE=+2 when rising, and INL=−2, GE=−6, OE=−2 when falling.
- R5: On an uncalibrated channel the margins are INL=+2, GE=+22, OE=+36 when rising, and INL=−2, GE=−26, OE=−36 when falling.
- R6: A request with req_mv < 0 or req_mv > 4095 raises res_reject for one cycle, in the cycle after acceptance. It gives no res_valid and leaves busy low.
- R7: A request in range with cal_gain = 0 raises res_valid in the cycle after acceptance, with res_code = 0 and res_err = 1. busy stays low.
- R8: An accepted in-range request with non-zero gain holds busy high. res_valid (with res_err=0) is high for exactly one cycle: 2·(DIV_W+2) cycles after the accepting edge when uncalibrated, and 3·(DIV_W+2) cycles when calibrated. busy drops at that same edge.
- R9: req_valid has no effect while busy is high. It does not change the pending result, its timing, or res_reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_mv | input | MV_W | Threshold in millivolts, signed |
| req_rise | input | 1 | 1 = rising threshold, 0 = falling |
| cal_valid_ch | input | 1 | Channel has calibration data |
| cal_gain | input | GAIN_W | Gain ×1000, signed |
| cal_k | input | K_W | Gain-error factor ×1000, signed |
| cal_offset | input | OFS_W | Offset ×1000, signed |
| busy | output | 1 | Conversion in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 12 | Raw comparator code |
| res_err | output | 1 | Result produced for a zero gain |
| res_reject | output | 1 | One-cycle pulse for an out-of-range threshold |

## Verification
The result of a converted request is due 2·(DIV_W+2) edges after the accepting edge on an uncalibrated channel and 3·(DIV_W+2) edges on a calibrated one. The reject and zero-gain answers are due on the edge right after acceptance. The bench reference model counts edges from acceptance and predicts, for every cycle, the expected levels of busy, res_valid and res_reject. The design is sampled on the falling edge and compared against that prediction each cycle, so a result that comes one cycle early or late fails just as a wrong code does. Requests made while busy are fed into the model as well, and the model drops them.

// File: rtl/thr_conv_pkg.sv
// Package: shared constants for the threshold-to-code converter.
// Assumes: 12-bit comparator codes; margins fit in 8-bit signed values.
package thr_conv_pkg;
    localparam int CODE_W   = 12;
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int SCALE    = 1000;
    localparam int MARG_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD1, ST_WAIT1, ST_LOAD2, ST_WAIT2, ST_LOAD3, ST_WAIT3
    } conv_state_t;
endpackage

// File: rtl/thr_sdiv.sv
// Module: sequential signed divider, one quotient bit per clock.
// Assumes: start is a single-cycle strobe while idle; the quotient truncates
// toward zero; done pulses DW+1 edges after the start edge.
module thr_sdiv #(
    parameter int DW = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [DW-1:0] dividend,
    input  logic signed [DW-1:0] divisor,
    output logic                 done,
    output logic signed [DW-1:0] quotient
);
    localparam int CNT_W = $clog2(DW + 1);

    logic [DW:0]      rem;
    logic [DW-1:0]    qacc;
    logic [DW-1:0]    dmag;
    logic [CNT_W-1:0] cnt;
    logic             neg;
    logic [DW:0]      rem_sh;
    logic             fits;

    // Purpose: one restoring shift-subtract step on the magnitudes.
    always_comb begin
        rem_sh = {rem[DW-1:0], qacc[DW-1]};
        fits   = (rem_sh >= {1'b0, dmag});
    end

    // Purpose: load the magnitudes on start, then step until the count ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            qacc <= '0;
            dmag <= '0;
            cnt  <= '0;
            neg  <= 1'b0;
            done <= 1'b0;
        end else if (start) begin
            rem  <= '0;
            qacc <= dividend[DW-1] ? DW'(-dividend) : DW'(dividend);
            dmag <= divisor[DW-1] ? DW'(-divisor) : DW'(divisor);
            neg  <= dividend[DW-1] ^ divisor[DW-1];
            cnt  <= CNT_W'(DW);
            done <= 1'b0;
        end else if (cnt != '0) begin
            rem  <= fits ? (rem_sh - {1'b0, dmag}) : rem_sh;
            qacc <= {qacc[DW-2:0], fits};
            cnt  <= cnt - 1'b1;
            done <= (cnt == CNT_W'(1));
        end else begin
            done <= 1'b0;
        end
    end

    // Purpose: put the sign back on the unsigned quotient.
    always_comb quotient = neg ? -$signed(qacc) : $signed(qacc);
endmodule

// File: rtl/thr_margin_sel.sv
// Module: chooses the worst-case INL, gain-error and offset-error margins.
// Assumes: rising margins are positive and falling margins negative; an
// uncalibrated channel widens gain error by UNCAL_GE_EXTRA.
module thr_margin_sel #(
    parameter int MW             = 8,
    parameter int INL_ABS        = 2,
    parameter int CAL_GE_UP      = 2,
    parameter int CAL_GE_DN      = 6,
    parameter int CAL_OE_ABS     = 2,
    parameter int UNCAL_GE_EXTRA = 20,
    parameter int UNCAL_OE_ABS   = 36
) (
    input  logic                 calibrated,
    input  logic                 rising,
    output logic signed [MW-1:0] inl,
    output logic signed [MW-1:0] gerr,
    output logic signed [MW-1:0] oerr
);
    localparam logic signed [MW-1:0] GE_CU = MW'(CAL_GE_UP);
    localparam logic signed [MW-1:0] GE_CD = MW'(-CAL_GE_DN);
    localparam logic signed [MW-1:0] GE_UU = MW'(CAL_GE_UP + UNCAL_GE_EXTRA);
    localparam logic signed [MW-1:0] GE_UD = MW'(-(CAL_GE_DN + UNCAL_GE_EXTRA));
    localparam logic signed [MW-1:0] OE_C  = MW'(CAL_OE_ABS);
    localparam logic signed [MW-1:0] OE_U  = MW'(UNCAL_OE_ABS);
    localparam logic signed [MW-1:0] INL_P = MW'(INL_ABS);

    // Purpose: pick the margin set from calibration state and direction.
    always_comb begin
        inl  = rising ? INL_P : -INL_P;
        gerr = calibrated ? (rising ? GE_CU : GE_CD) : (rising ? GE_UU : GE_UD);
        oerr = calibrated ? (rising ? OE_C : -OE_C) : (rising ? OE_U : -OE_U);
    end
endmodule

// File: rtl/thresh_code_conv.sv
// Module: converts a millivolt threshold to a 12-bit raw comparator code.
// Assumes: the calibration inputs are held steady while req_valid is high;
// a single shared divider runs the ideal, calibration and tolerance steps in turn.
module thresh_code_conv #(
    parameter int MV_W   = 16,
    parameter int GAIN_W = 16,
    parameter int K_W    = 16,
    parameter int OFS_W  = 32,
    parameter int DIV_W  = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic signed [MV_W-1:0]   req_mv,
    input  logic                     req_rise,
    input  logic                     cal_valid_ch,
    input  logic signed [GAIN_W-1:0] cal_gain,
    input  logic signed [K_W-1:0]    cal_k,
    input  logic signed [OFS_W-1:0]  cal_offset,
    output logic                     busy,
    output logic                     res_valid,
    output logic [11:0]              res_code,
    output logic                     res_err,
    output logic                     res_reject
);
    import thr_conv_pkg::*;

    localparam logic signed [DIV_W-1:0] K1000  = DIV_W'(SCALE);
    localparam logic signed [DIV_W-1:0] CMAX_X = DIV_W'(CODE_MAX);
    localparam logic signed [MV_W-1:0]  MV_MAX = MV_W'(CODE_MAX);

    conv_state_t               state;
    logic signed [MV_W-1:0]    mv_r;
    logic signed [GAIN_W-1:0]  gain_r;
    logic signed [K_W-1:0]     k_r;
    logic signed [OFS_W-1:0]   ofs_r;
    logic                      cal_r;
    logic                      rise_r;
    logic signed [DIV_W-1:0]   code_r;
    logic signed [MARG_W-1:0]  m_inl;
    logic signed [MARG_W-1:0]  m_gerr;
    logic signed [MARG_W-1:0]  m_oerr;
    logic                      div_start;
    logic                      div_done;
    logic signed [DIV_W-1:0]   div_a;
    logic signed [DIV_W-1:0]   div_b;
    logic signed [DIV_W-1:0]   div_q;
    logic signed [DIV_W-1:0]   final_v;
    logic                      in_range;

    thr_margin_sel #(.MW(MARG_W)) i_margin (
        .calibrated (cal_r),
        .rising     (rise_r),
        .inl        (m_inl),
        .gerr       (m_gerr),
        .oerr       (m_oerr)
    );

    thr_sdiv #(.DW(DIV_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quotient (div_q)
    );

    // Purpose: choose the divider operands for the step in progress.
    always_comb begin
        div_start = (state == ST_LOAD1) || (state == ST_LOAD2) || (state == ST_LOAD3);
        div_a     = '0;
        div_b     = K1000;
        case (state)
            ST_LOAD1: begin
                div_a = DIV_W'(mv_r) * K1000;
                div_b = DIV_W'(gain_r);
            end
            ST_LOAD2: div_a = rise_r ? (code_r * DIV_W'(k_r) + DIV_W'(ofs_r))
                                     : (code_r * DIV_W'(k_r) - DIV_W'(ofs_r));
            ST_LOAD3: div_a = (code_r + DIV_W'(m_inl)) * (K1000 + DIV_W'(m_gerr));
            default: ;
        endcase
    end

    // Purpose: final offset-error shift and the range test on the request.
    always_comb begin
        final_v  = div_q + DIV_W'(m_oerr);
        in_range = (req_mv >= 0) && (req_mv <= MV_MAX);
    end

    // Purpose: sequence the three conversion steps and drive the result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mv_r       <= '0;
            gain_r     <= '0;
            k_r        <= '0;
            ofs_r      <= '0;
            cal_r      <= 1'b0;
            rise_r     <= 1'b0;
            code_r     <= '0;
            res_valid  <= 1'b0;
            res_code   <= '0;
            res_err    <= 1'b0;
            res_reject <= 1'b0;
        end else begin
            res_valid  <= 1'b0;
            res_reject <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    if (!in_range) begin
                        res_reject <= 1'b1;
                    end else if (cal_gain == '0) begin
                        res_valid <= 1'b1;
                        res_code  <= '0;
                        res_err   <= 1'b1;
                    end else begin
                        mv_r   <= req_mv;
                        gain_r <= cal_gain;
                        k_r    <= cal_k;
                        ofs_r  <= cal_offset;
                        cal_r  <= cal_valid_ch;
                        rise_r <= req_rise;
                        state  <= ST_LOAD1;
                    end
                end
                ST_LOAD1: state <= ST_WAIT1;
                ST_LOAD2: state <= ST_WAIT2;
                ST_LOAD3: state <= ST_WAIT3;
                ST_WAIT1: if (div_done) begin
                    code_r <= div_q;
                    state  <= cal_r ? ST_LOAD2 : ST_LOAD3;
                end
                ST_WAIT2: if (div_done) begin
                    code_r <= div_q;
                    state  <= ST_LOAD3;
                end
                ST_WAIT3: if (div_done) begin
                    res_valid <= 1'b1;
                    res_err   <= 1'b0;
                    if (final_v < 0)
                        res_code <= '0;
                    else if (final_v > CMAX_X)
                        res_code <= 12'(CODE_MAX);
                    else
                        res_code <= 12'(final_v);
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: expose the busy flag while a conversion is in flight.
    always_comb busy = (state != ST_IDLE);
endmodule

// File: rtl/thr_conv_chk.sv
// Module: protocol checker for thresh_code_conv, bound to every instance.
// Assumes: synchronous active-low reset; strobes are one cycle wide.
module thr_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        res_valid,
    input logic [11:0] res_code,
    input logic        res_err,
    input logic        res_reject
);
    AST_REJECT_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_reject |-> (!res_valid && !busy)); // R6
    AST_REJECT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        res_reject |-> ($past(req_valid) && !$past(busy))); // R6
    AST_ZERO_GAIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err) |-> (res_code == 12'd0 && !$past(busy))); // R7
    AST_RESULT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (res_valid && !res_err)); // R8
    AST_CONV_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_err) |-> $past(busy)); // R8
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> (busy || res_valid)); // R9
endmodule

bind thresh_code_conv thr_conv_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .res_valid  (res_valid),
    .res_code   (res_code),
    .res_err    (res_err),
    .res_reject (res_reject)
);

// File: tb/test_thresh_code_conv.sv
module test_thresh_code_conv;
    localparam int DIV_W = 48;
    localparam int STAGE = DIV_W + 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic signed [15:0] req_mv = '0;
    logic               req_rise = 1'b0;
    logic               cal_valid_ch = 1'b0;
    logic signed [15:0] cal_gain = '0;
    logic signed [15:0] cal_k = '0;
    logic signed [31:0] cal_offset = '0;
    logic               busy;
    logic               res_valid;
    logic [11:0]        res_code;
    logic               res_err;
    logic               res_reject;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string tag = "RST";

    // reference model state
    int     m_left = 0;
    bit     m_valid = 1'b0;
    bit     m_rej = 1'b0;
    bit     m_err = 1'b0;
    longint m_code = 0;
    longint m_pend = 0;

    always #4 clk = ~clk;

    thresh_code_conv #(.DIV_W(DIV_W)) i_thresh_code_conv (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mv(req_mv),
        .req_rise(req_rise), .cal_valid_ch(cal_valid_ch), .cal_gain(cal_gain),
        .cal_k(cal_k), .cal_offset(cal_offset), .busy(busy),
        .res_valid(res_valid), .res_code(res_code), .res_err(res_err),
        .res_reject(res_reject)
    );

    function automatic longint expect_code(longint mv, longint g, longint k,
                                           longint ofs, bit cal, bit rise);
        longint c;
        longint inl;
        longint ge;
        longint oe;
        c = (mv * 1000) / g;                                   // R1
        if (cal) c = rise ? (c * k + ofs) / 1000 : (c * k - ofs) / 1000; // R2
        inl = rise ? 2 : -2;
        if (cal) begin ge = rise ? 2 : -6;  oe = rise ? 2 : -2;  end   // R4
        else     begin ge = rise ? 22 : -26; oe = rise ? 36 : -36; end // R5
        c = ((c + inl) * (1000 + ge)) / 1000 + oe;             // R3
        if (c < 0) c = 0;
        if (c > 4095) c = 4095;
        return c;
    endfunction

    task automatic check(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        m_valid = 1'b0;
        m_rej = 1'b0;
        if (!rst_n) begin
            m_left = 0; m_code = 0; m_err = 1'b0;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin m_valid = 1'b1; m_code = m_pend; m_err = 1'b0; end
        end else if (req_valid) begin
            if (req_mv < 0 || req_mv > 4095) m_rej = 1'b1;
            else if (cal_gain == 0) begin m_valid = 1'b1; m_code = 0; m_err = 1'b1; end
            else begin
                m_pend = expect_code(req_mv, cal_gain, cal_k, cal_offset, cal_valid_ch, req_rise);
                m_left = cal_valid_ch ? 3 * STAGE : 2 * STAGE;
            end
        end
        @(negedge clk);
        check(busy == (m_left > 0), "busy", busy, m_left > 0);
        check(res_valid == m_valid, "res_valid", res_valid, m_valid);
        check(res_reject == m_rej, "res_reject", res_reject, m_rej);
        if (m_valid && res_valid) begin
            check(res_code == m_code, "res_code", res_code, m_code);
            check(res_err == m_err, "res_err", res_err, m_err);
        end
    endtask

    task automatic run_req(string t, int mv, int g, int k, int ofs, bit cal, bit rise);
        tag = t;
        req_mv = 16'(mv); cal_gain = 16'(g); cal_k = 16'(k); cal_offset = 32'(ofs);
        cal_valid_ch = cal; req_rise = rise; req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        while (m_left > 0) tick();
        tick();
    endtask

    initial begin
        repeat (3) tick();                      // reset state
        rst_n = 1'b1;
        tick();
        run_req("R1 R3 R4 cal rise", 800, 305, 1003, 5000, 1'b1, 1'b1);
        run_req("R2 R4 cal fall", 800, 305, 1003, 5000, 1'b1, 1'b0);
        run_req("R2 negative offset", 1500, 610, 997, -7000, 1'b1, 1'b1);
        run_req("R5 uncal rise", 900, 305, 0, 0, 1'b0, 1'b1);
        run_req("R5 uncal fall", 900, 305, 0, 0, 1'b0, 1'b0);
        run_req("R1 negative gain", 300, -305, 0, 0, 1'b0, 1'b0);
        run_req("R3 clamp high", 4095, 100, 1000, 0, 1'b1, 1'b1);
        run_req("R3 clamp low", 0, 305, 1000, 0, 1'b1, 1'b0);
        run_req("R6 top edge accepted", 4095, 1221, 1002, 3000, 1'b1, 1'b1);
        run_req("R6 negative rejected", -1, 305, 1000, 0, 1'b1, 1'b1);
        run_req("R6 above range rejected", 4096, 305, 1000, 0, 1'b0, 1'b1);
        run_req("R7 zero gain", 1000, 0, 1000, 0, 1'b1, 1'b1);
        run_req("R7 zero gain uncal", 5, 0, 0, 0, 1'b0, 1'b0);
        // R8/R9: requests while busy must be ignored
        tag = "R8 R9 busy ignore";
        req_mv = 16'sd1200; cal_gain = 16'sd305; cal_k = 16'sd1004; cal_offset = 32'sd2000;
        cal_valid_ch = 1'b1; req_rise = 1'b1; req_valid = 1'b1;
        tick();
        req_mv = 16'sd3000; cal_valid_ch = 1'b0;
        repeat (10) tick();
        req_mv = -16'sd5;
        repeat (3) tick();
        req_valid = 1'b0;
        req_mv = 16'sd1200; cal_valid_ch = 1'b1;
        while (m_left > 0) tick();
        tick();
        // R8: back-to-back acceptance on the cycle the result appears
        tag = "R8 back to back";
        req_mv = 16'sd600; cal_gain = 16'sd610; cal_valid_ch = 1'b0; req_rise = 1'b0;
        req_valid = 1'b1;
        tick();
        while (m_left > 0) tick();
        tick();
        req_valid = 1'b0;
        repeat (2) tick();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule